// File: doc/BRIEF.md
# Successive Approximation Readback Controller

This block measures an analog level with a 12-bit successive-approximation search. It drives trial codes to an external readback DAC and reads a single comparator bit. That bit tells it whether the current trial level is at or below the signal coming out of an analog channel multiplexer. The DAC has only an 8-bit data bus, so every trial code goes out as two bus writes: the low byte first, then the high nibble. A byte-select line marks which of the two is on the bus, and the DAC assembles the full word from them.

After the high-byte write, the controller waits a programmable number of settle cycles so that the DAC and the comparator can settle. It then samples the comparator and decides the trial bit. Trials run from the most significant bit down to the least significant one. The decided bits build up in an accumulator, and that value is the measurement once the last bit is decided.

A conversion starts with a one-cycle start strobe. The strobe carries a channel number, which is held on the multiplexer select for the whole conversion, and the settle count in use at that moment. The end of a conversion is marked by a one-cycle done pulse, with the result valid on the same cycle.

Top module: `sar_readback_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and bus_wr_o are 0 and result_o is 0.
- R2: A start_i seen while idle begins a conversion. busy_o is 1 from the next cycle on, and mux_sel_o shows the chan_i value captured with the start, unchanged until the conversion ends.
- R3: Each trial is exactly two consecutive write cycles (bus_wr_o=1). The first has bus_hi_o=0 and bus_data_o = trial[7:0]. The second has bus_hi_o=1 and bus_data_o[3:0] = trial[11:8], with bus_data_o[7:4] = 0.
- R4: The first trial code is 0x800. Each trial code is the accumulated code with one trial bit set, and the trial bit moves from bit 11 down to bit 0, one position per trial.
- R5: After the high-byte write, exactly S idle cycles pass, where S is the settle_i value captured at start (S=0 allowed). The comparator is sampled in the cycle after them, and no bus write happens in between.
- R6: cmp_i=1 at sampling (trial level at or below the signal) keeps the trial bit. cmp_i=0 clears it. For an ideal comparator the result therefore equals the measured code.
- R7: done_o is high for exactly one cycle, 12*(S+3) clock edges after the edge that accepted the start. In that cycle busy_o is 0 and result_o holds the final code, which stays until the next done.
- R8: A start_i that arrives while busy_o=1 has no effect on the channel, the timing or the result.

Port descriptions use two enumerated values: S is the settle count captured at start, and trial is the current trial code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| chan_i | input | 3 | Multiplexer channel for the conversion |
| settle_i | input | 8 | Settle cycles after each high-byte write |
| cmp_i | input | 1 | Comparator: 1 when trial level is at or below the signal |
| bus_data_o | output | 8 | DAC bus data byte |
| bus_wr_o | output | 1 | DAC bus write strobe |
| bus_hi_o | output | 1 | Byte select: 0 low byte, 1 high nibble |
| mux_sel_o | output | 3 | Held channel select |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 12 | Last conversion result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A start accepted at one edge shows up as busy and as the low-byte write after that same edge. Each trial then takes S+3 edges, and done arrives 12*(S+3) edges after the accepting edge. A behavioural model in the bench follows the same cycle count, steps at every rising edge, and is compared with every output at the falling edge. The bench comparator gives the wrong answer until S edges after the high-byte latch. Sampling one cycle early therefore corrupts the result, and the result check reports it against the known input code. A separate edge counter checks the done latency.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation readback controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package sar_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LO,
        ST_WR_HI,
        ST_SETTLE,
        ST_SAMPLE
    } sar_state_e;
endpackage

// File: rtl/sar_settle_timer.sv
// Down-counter that times the DAC settle window after a high-byte write.
// Assumes load_i pulses once per trial. expired_o is high when at most one cycle is left.
module sar_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= count_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Last settle cycle is the one where one count remains.
    assign expired_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/sar_bus_framer.sv
// Splits a trial code into the byte placed on the narrow DAC bus.
// Assumes RES_W > BUS_W and RES_W - BUS_W <= BUS_W. The high part is zero-extended.
module sar_bus_framer #(
    parameter int RES_W = 12,
    parameter int BUS_W = 8
) (
    input  logic [RES_W-1:0] trial_i,
    input  logic             hi_sel_i,
    output logic [BUS_W-1:0] data_o
);
    localparam int HI_W = RES_W - BUS_W;

    logic [BUS_W-1:0] hi_byte;

    generate
        if (HI_W < BUS_W) begin : g_pad
            // Upper bits of the high transfer are zero.
            assign hi_byte = {{(BUS_W-HI_W){1'b0}}, trial_i[RES_W-1:BUS_W]};
        end else begin : g_full
            // High part fills the bus exactly.
            assign hi_byte = trial_i[RES_W-1:BUS_W];
        end
    endgenerate

    // Select which half of the trial code drives the bus.
    always_comb data_o = hi_sel_i ? hi_byte : trial_i[BUS_W-1:0];
endmodule

// File: rtl/sar_seq.sv
// Conversion sequencer: runs the bit trials from MSB to LSB and keeps the accumulator.
// Assumes the settle timer is loaded during the high-byte write. cmp_i is sampled in ST_SAMPLE.
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int CH_W  = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [CNT_W-1:0] settle_i,
    input  logic             cmp_i,
    input  logic             expired_i,
    output logic             load_o,
    output logic [CNT_W-1:0] settle_o,
    output logic [RES_W-1:0] trial_o,
    output logic             wr_o,
    output logic             hi_o,
    output logic [CH_W-1:0]  mux_sel_o,
    output logic             busy_o,
    output logic [RES_W-1:0] result_o,
    output logic             done_o
);
    localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};

    sar_state_e       state_q;
    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] mask_q;
    logic [CH_W-1:0]  chan_q;
    logic [CNT_W-1:0] settle_q;
    logic [RES_W-1:0] result_q;
    logic             done_q;
    logic [RES_W-1:0] acc_next;

    // Accumulator after deciding the current trial bit.
    always_comb acc_next = cmp_i ? (acc_q | mask_q) : acc_q;

    // State, accumulator, trial mask and the values captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            acc_q    <= '0;
            mask_q   <= '0;
            chan_q   <= '0;
            settle_q <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q  <= ST_WR_LO;
                        acc_q    <= '0;
                        mask_q   <= MSB_MASK;
                        chan_q   <= chan_i;
                        settle_q <= settle_i;
                    end
                end
                ST_WR_LO:  state_q <= ST_WR_HI;
                ST_WR_HI:  state_q <= (settle_q == '0) ? ST_SAMPLE : ST_SETTLE;
                ST_SETTLE: if (expired_i) state_q <= ST_SAMPLE;
                ST_SAMPLE: begin
                    acc_q <= acc_next;
                    if (mask_q[0]) begin
                        state_q  <= ST_IDLE;
                        result_q <= acc_next;
                        done_q   <= 1'b1;
                    end else begin
                        mask_q  <= mask_q >> 1;
                        state_q <= ST_WR_LO;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus strobes, trial code and status derived from the state.
    always_comb begin
        wr_o      = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
        hi_o      = (state_q == ST_WR_HI);
        load_o    = (state_q == ST_WR_HI);
        busy_o    = (state_q != ST_IDLE);
        trial_o   = acc_q | mask_q;
        settle_o  = settle_q;
        mux_sel_o = chan_q;
        result_o  = result_q;
        done_o    = done_q;
    end

    // A low-byte write is always followed by a high-byte write.
    assert_wr_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && !hi_o) |=> (wr_o && hi_o));

    // No bus write between the high-byte write and the sample.
    assert_no_early_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && hi_o) |=> !wr_o);

    // The first trial after a start carries only the MSB.
    assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (trial_o == MSB_MASK));

    // The channel select does not move during a conversion.
    assert_chan_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mux_sel_o));

    // Done is a single-cycle pulse and never coincides with busy.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o ##1 !done_o));
endmodule

// File: rtl/sar_readback_ctrl.sv
// Top of the successive-approximation readback controller.
// Sends each trial code as two DAC bus writes, waits out the settle count and decides one bit per trial.
// Assumes cmp_i is synchronous to clk.
module sar_readback_ctrl #(
    parameter int RES_W = 12,
    parameter int BUS_W = 8,
    parameter int CH_W  = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [CNT_W-1:0] settle_i,
    input  logic             cmp_i,
    output logic [BUS_W-1:0] bus_data_o,
    output logic             bus_wr_o,
    output logic             bus_hi_o,
    output logic [CH_W-1:0]  mux_sel_o,
    output logic             busy_o,
    output logic [RES_W-1:0] result_o,
    output logic             done_o
);
    logic             load_w;
    logic             expired_w;
    logic [CNT_W-1:0] settle_w;
    logic [RES_W-1:0] trial_w;

    sar_seq #(.RES_W(RES_W), .CH_W(CH_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .chan_i    (chan_i),
        .settle_i  (settle_i),
        .cmp_i     (cmp_i),
        .expired_i (expired_w),
        .load_o    (load_w),
        .settle_o  (settle_w),
        .trial_o   (trial_w),
        .wr_o      (bus_wr_o),
        .hi_o      (bus_hi_o),
        .mux_sel_o (mux_sel_o),
        .busy_o    (busy_o),
        .result_o  (result_o),
        .done_o    (done_o)
    );

    sar_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_w),
        .count_i   (settle_w),
        .expired_o (expired_w)
    );

    sar_bus_framer #(.RES_W(RES_W), .BUS_W(BUS_W)) u_framer (
        .trial_i  (trial_w),
        .hi_sel_i (bus_hi_o),
        .data_o   (bus_data_o)
    );
endmodule

// File: tb/sar_readback_ctrl_tb.sv
// Bench: behavioural DAC and comparator, plus a per-cycle reference model of the controller.
module sar_readback_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  chan_i = '0;
    logic [7:0]  settle_i = '0;
    logic        cmp_i = 1'b0;
    logic [7:0]  bus_data_o;
    logic        bus_wr_o, bus_hi_o, busy_o, done_o;
    logic [2:0]  mux_sel_o;
    logic [11:0] result_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Analog side: the measured code and the DAC word latched from the bus.
    int vin = 0;
    int dac_lo = 0;
    int dac_word = 0;
    int since_hi = 1000;
    int cur_settle = 0;

    // Reference model state.
    bit m_busy = 0, m_done = 0;
    int m_ch = 0, m_s = 0, m_acc = 0, m_bit = 0, m_step = 0, m_res = 0;

    sar_readback_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .settle_i(settle_i), .cmp_i(cmp_i), .bus_data_o(bus_data_o),
        .bus_wr_o(bus_wr_o), .bus_hi_o(bus_hi_o), .mux_sel_o(mux_sel_o),
        .busy_o(busy_o), .result_o(result_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model advances on each rising edge from the inputs held stable there.
    always @(posedge clk) begin
        cycles++;
        m_done = 0;
        if (!rst_n) begin
            m_busy = 0; m_res = 0; m_acc = 0; m_step = 0;
        end else if (!m_busy) begin
            if (start_i) begin
                m_busy = 1; m_ch = chan_i; m_s = settle_i;
                m_acc = 0; m_bit = 11; m_step = 0;
            end
        end else if (m_step == m_s + 2) begin
            if (cmp_i) m_acc = m_acc | (1 << m_bit);
            if (m_bit == 0) begin
                m_done = 1; m_res = m_acc; m_busy = 0;
            end else begin
                m_bit--; m_step = 0;
            end
        end else begin
            m_step++;
        end
    end

    // Falling edge: compare the outputs, then drive the comparator and track the DAC.
    always @(negedge clk) begin
        int trial;
        trial = m_acc | (1 << m_bit);
        if (rst_n || cycles > 1) begin
            check(busy_o === m_busy, "R2 busy", busy_o, m_busy);
            check(done_o === m_done, "R7 done", done_o, m_done);
            check(result_o === 12'(m_res), "R7 result", result_o, m_res);
            check(bus_wr_o === (m_busy && m_step < 2), "R3/R5 bus_wr", bus_wr_o, m_busy && m_step < 2);
            if (m_busy) begin
                check(mux_sel_o === 3'(m_ch), "R2/R8 mux_sel", mux_sel_o, m_ch);
                if (m_step == 0) begin
                    check(bus_hi_o === 1'b0, "R3 low select", bus_hi_o, 0);
                    check(bus_data_o === 8'(trial & 8'hFF), "R4 low byte", bus_data_o, trial & 8'hFF);
                end
                if (m_step == 1) begin
                    check(bus_hi_o === 1'b1, "R3 high select", bus_hi_o, 1);
                    check(bus_data_o === 8'(trial >> 8), "R4 high nibble", bus_data_o, trial >> 8);
                end
            end
        end
        // The comparator answers wrongly until the settle window has passed (R5).
        cmp_i = (since_hi >= cur_settle) ? (dac_word <= vin) : !(dac_word <= vin);
        if (bus_wr_o === 1'b1 && bus_hi_o === 1'b0) dac_lo = bus_data_o;
        if (bus_wr_o === 1'b1 && bus_hi_o === 1'b1) begin
            dac_word = ((bus_data_o & 8'h0F) << 8) | dac_lo;
            since_hi = 0;
        end else if (since_hi < 1000) begin
            since_hi++;
        end
    end

    // One conversion; optionally pokes a start in the middle to test that it is ignored.
    task automatic convert(input int code, input int s, input int ch, input bit poke);
        int n;
        vin = code; cur_settle = s;
        @(negedge clk);
        start_i = 1'b1; chan_i = 3'(ch); settle_i = 8'(s);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0; settle_i = 8'(s + 4); chan_i = 3'(ch + 1);
        n = 0;
        while (done_o !== 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
            if (poke && n == 7) start_i = 1'b1;
            if (poke && n == 8) start_i = 1'b0;
        end
        check(n == 12 * (s + 3), "R7 latency", n, 12 * (s + 3));
        check(result_o === 12'(code), "R6/R5 result equals input", result_o, code);
        if (poke) check(mux_sel_o === 3'(ch), "R8 channel kept", mux_sel_o, ch);
        @(negedge clk);
        check(done_o === 1'b0, "R7 done single cycle", done_o, 0);
        check(result_o === 12'(code), "R7 result held", result_o, code);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0 && bus_wr_o === 1'b0,
              "R1 idle after reset", {busy_o, done_o, bus_wr_o}, 0);
        check(result_o === 12'd0, "R1 result cleared", result_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        convert(12'hA5C, 0, 2, 0);
        convert(0, 1, 5, 0);
        convert(12'hFFF, 5, 7, 1);
        convert(12'h800, 3, 1, 0);
        convert(12'h7FF, 2, 6, 1);
        convert(12'h001, 0, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule